// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block is the control-transfer engine of a small CPU with 16-bit addresses and 8-bit data. It runs three two-byte instructions, which reach it already decoded as an opcode strobe with a vector operand. The first is a call through a vector table held in the first 256 bytes of memory. The second is a subroutine return. The third is a return from exception, which brings back the condition-code byte as well as the program counter.

The block holds the architectural program counter, stack pointer and condition-code register. It reaches memory through a simple synchronous byte port: a read strobe returns data on the next cycle, and a write strobe stores the byte at the clock edge. Words are big-endian, with the high byte at the lower address.

Each operation takes a fixed number of cycles. The new architectural values become visible together on the cycle after the `done` pulse. While a sequence runs, the block ignores any new opcode strobe.

Top module: `ctlx_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. `busy` and `done` go to 0 and no memory strobe is active. `pc` is set to PC_RST (0x0200), `sp` to SP_RST (0x0380) and `ccr` to CCR_RST (0x80).
- R2: The opcode encoding is 2'b01 for call, 2'b10 for subroutine return and 2'b11 for exception return. An op is accepted at a clock edge where `op_valid` is high, the kind is not 2'b00 and `busy` is low. When the kind is 2'b00 the strobe has no effect.
- R3: A call pushes `pc`+2 as a word at `sp`-2: the high byte goes to `sp`-2 and the low byte to `sp`-1. The new `sp` is `sp`-2. The new `pc` is the word at the zero-extended vector address V and V+1. For V=0xFF the low byte comes from 0x0100.
- R4: A subroutine return loads `pc` from the word at `sp` and adds 2 to `sp`.
- R5: An exception return loads `ccr` from the byte at `sp`. The byte at `sp`+1 is not used. It then loads `pc` from the word at `sp`+2 and adds 4 to `sp`.
- R6: A call or a subroutine return leaves `ccr` unchanged. The bit layout of `ccr` is I=7, H=5, N=3, Z=2, V=1, C=0.
- R7: After acceptance, `busy` stays high for exactly 8 cycles (call, subroutine return) or 10 cycles (exception return). `done` is high in the last of those cycles only. `pc`, `sp` and `ccr` change only on the cycle after `done`, and all at once.
- R8: An opcode strobe that arrives while `busy` is high is ignored. It neither extends the running sequence nor starts another one.
- R9: At most one of `mem_rd` and `mem_wr` is high in any cycle, and both are low while `busy` is low. The data for a read appears on `mem_rdata` in the cycle after `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Opcode strobe |
| op_kind | input | 2 | Operation: 01 call, 10 return, 11 exception return |
| op_vec | input | 8 | Vector-table byte address for a call |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Final cycle of a sequence |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| ccr | output | 8 | Condition-code register |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |

## Verification
The assertions assume that `op_kind` and `op_valid` are steady between clock edges. They also assume that memory returns read data exactly one cycle after the strobe and never stalls. Under those assumptions the fixed cycle schedule and the hold of the architectural state during a sequence can be checked without any handshake. The bench keeps to this by changing inputs only on falling edges and by modelling memory as a registered array with a one-cycle read. It places the vector table and the stack in separate areas so that the pushes made by calls never overwrite table entries.

// File: rtl/ctlx_pkg.sv
// Package: types and constants shared by the call/return sequencer.
// Assumes an 8-bit data path and a 16-bit byte address.
package ctlx_pkg;
    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 2 * BYTE_W;
    localparam int VEC_W       = 8;
    localparam int CALL_STATES = 8;
    localparam int RET_STATES  = 8;
    localparam int RTE_STATES  = 10;
    localparam int STEP_W      = $clog2(RTE_STATES);

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_CALL = 2'b01,
        OP_RET  = 2'b10,
        OP_RTE  = 2'b11
    } op_e;

    // Destination of the byte on the read-data bus this cycle.
    typedef enum logic [1:0] {
        CAP_NONE,
        CAP_HI,
        CAP_LO,
        CAP_CCR
    } cap_e;

    // Index of the final state of each operation.
    function automatic logic [STEP_W-1:0] last_step(op_e op);
        case (op)
            OP_CALL: last_step = STEP_W'(CALL_STATES - 1);
            OP_RET:  last_step = STEP_W'(RET_STATES - 1);
            OP_RTE:  last_step = STEP_W'(RTE_STATES - 1);
            default: last_step = '0;
        endcase
    endfunction
endpackage

// File: rtl/ctlx_seq_ctl.sv
// Sequence control: accepts an opcode while idle, latches it together
// with the vector operand, and steps a counter up to the final state of
// the operation. Strobes that arrive while busy are dropped.
module ctlx_seq_ctl
    import ctlx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  op_e               op_kind,
    input  logic [VEC_W-1:0]  op_vec,
    output logic              busy,
    output logic              done,
    output op_e               cur_op,
    output logic [VEC_W-1:0]  cur_vec,
    output logic [STEP_W-1:0] step
);
    // Final-state flag.
    assign done = busy && (step == last_step(cur_op));

    // Acceptance, stepping and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            step    <= '0;
            cur_op  <= OP_NONE;
            cur_vec <= '0;
        end else if (!busy) begin
            if (op_valid && op_kind != OP_NONE) begin
                busy    <= 1'b1;
                step    <= '0;
                cur_op  <= op_kind;
                cur_vec <= op_vec;
            end
        end else if (done) begin
            busy <= 1'b0;
            step <= '0;
        end else begin
            step <= step + 1'b1;
        end
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_valid && op_kind != OP_NONE) |=>
            (busy && step == '0 && cur_op == $past(op_kind)));

    p_none_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (!op_valid || op_kind == OP_NONE)) |=> !busy);

    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=>
            (busy && step == $past(step) + 1'b1 && cur_op == $past(cur_op)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/ctlx_mem_plan.sv
// Memory schedule: combinational decode of (operation, step) into the
// memory strobe, address and write data, and into the destination of
// the byte returned by the read issued one step earlier.
// Assumes pc and sp hold still while a sequence runs.
module ctlx_mem_plan
    import ctlx_pkg::*;
(
    input  logic              busy,
    input  op_e               cur_op,
    input  logic [STEP_W-1:0] step,
    input  logic [VEC_W-1:0]  cur_vec,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] sp,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output cap_e              cap
);
    logic [ADDR_W-1:0] ret_pc;
    logic [ADDR_W-1:0] push_at;
    logic [ADDR_W-1:0] vec_at;

    assign ret_pc  = pc + ADDR_W'(2);
    assign push_at = sp - ADDR_W'(2);
    assign vec_at  = {{(ADDR_W - VEC_W){1'b0}}, cur_vec};

    // Per-step memory action and capture target.
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        cap       = CAP_NONE;
        if (busy) begin
            case (cur_op)
                OP_CALL: case (int'(step))
                    0: begin mem_wr = 1'b1; mem_addr = push_at;
                             mem_wdata = ret_pc[ADDR_W-1:BYTE_W]; end
                    1: begin mem_wr = 1'b1; mem_addr = push_at + 1'b1;
                             mem_wdata = ret_pc[BYTE_W-1:0]; end
                    2: begin mem_rd = 1'b1; mem_addr = vec_at; end
                    3: begin mem_rd = 1'b1; mem_addr = vec_at + 1'b1;
                             cap = CAP_HI; end
                    4: cap = CAP_LO;
                    default: ;
                endcase
                OP_RET: case (int'(step))
                    0: begin mem_rd = 1'b1; mem_addr = sp; end
                    1: begin mem_rd = 1'b1; mem_addr = sp + 1'b1;
                             cap = CAP_HI; end
                    2: cap = CAP_LO;
                    default: ;
                endcase
                OP_RTE: case (int'(step))
                    0: begin mem_rd = 1'b1; mem_addr = sp; end
                    1: begin mem_rd = 1'b1; mem_addr = sp + ADDR_W'(2);
                             cap = CAP_CCR; end
                    2: begin mem_rd = 1'b1; mem_addr = sp + ADDR_W'(3);
                             cap = CAP_HI; end
                    3: cap = CAP_LO;
                    default: ;
                endcase
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ctlx_arch_regs.sv
// Architectural state: gathers the bytes read during a sequence into
// staging registers, then updates pc, sp and ccr together on commit.
// Assumes commit is a single-cycle pulse that arrives after the last capture.
module ctlx_arch_regs
    import ctlx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PC_RST  = 16'h0200,
    parameter logic [ADDR_W-1:0] SP_RST  = 16'h0380,
    parameter logic [BYTE_W-1:0] CCR_RST = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cap_e              cap,
    input  logic [BYTE_W-1:0] rdata,
    input  logic              commit,
    input  op_e               cur_op,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] sp,
    output logic [BYTE_W-1:0] ccr
);
    logic [BYTE_W-1:0] hi_q, lo_q, ccr_q;

    // Staging of bytes returned by memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            ccr_q <= '0;
        end else begin
            case (cap)
                CAP_HI:  hi_q  <= rdata;
                CAP_LO:  lo_q  <= rdata;
                CAP_CCR: ccr_q <= rdata;
                default: ;
            endcase
        end
    end

    // Atomic architectural update at the end of a sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= PC_RST;
            sp  <= SP_RST;
            ccr <= CCR_RST;
        end else if (commit) begin
            pc <= {hi_q, lo_q};
            case (cur_op)
                OP_CALL: sp <= sp - ADDR_W'(2);
                OP_RET:  sp <= sp + ADDR_W'(2);
                OP_RTE: begin
                    sp  <= sp + ADDR_W'(4);
                    ccr <= ccr_q;
                end
                default: ;
            endcase
        end
    end

    p_ccr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cur_op != OP_RTE) |=> ccr == $past(ccr));
endmodule

// File: rtl/ctlx_seq.sv
// Top of the call/return sequencer: control, memory schedule and
// architectural registers. Memory is a synchronous byte port with
// one-cycle read latency and no stall.
module ctlx_seq
    import ctlx_pkg::*;
#(
    parameter logic [15:0] PC_RST  = 16'h0200,
    parameter logic [15:0] SP_RST  = 16'h0380,
    parameter logic [7:0]  CCR_RST = 8'h80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [1:0]  op_kind,
    input  logic [7:0]  op_vec,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] pc,
    output logic [15:0] sp,
    output logic [7:0]  ccr,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_rd,
    output logic        mem_wr
);
    op_e               cur_op;
    logic [VEC_W-1:0]  cur_vec;
    logic [STEP_W-1:0] step;
    cap_e              cap;

    ctlx_seq_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_kind  (op_e'(op_kind)),
        .op_vec   (op_vec),
        .busy     (busy),
        .done     (done),
        .cur_op   (cur_op),
        .cur_vec  (cur_vec),
        .step     (step)
    );

    ctlx_mem_plan u_plan (
        .busy      (busy),
        .cur_op    (cur_op),
        .step      (step),
        .cur_vec   (cur_vec),
        .pc        (pc),
        .sp        (sp),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .cap       (cap)
    );

    ctlx_arch_regs #(
        .PC_RST  (PC_RST),
        .SP_RST  (SP_RST),
        .CCR_RST (CCR_RST)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap),
        .rdata  (mem_rdata),
        .commit (done),
        .cur_op (cur_op),
        .pc     (pc),
        .sp     (sp),
        .ccr    (ccr)
    );

    p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_arch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(pc) && $stable(sp) && $stable(ccr)));
endmodule

// File: tb/ctlx_seq_tb.sv
// Bench: behavioural reference model advanced on every rising edge and
// compared against the design's ports on every falling edge.
module ctlx_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] PC_RST  = 16'h0200;
    localparam logic [15:0] SP_RST  = 16'h0380;
    localparam logic [7:0]  CCR_RST = 8'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [7:0]  op_vec = 8'h00;
    logic [7:0]  mem_rdata;
    logic        busy, done, mem_rd, mem_wr;
    logic [15:0] pc, sp, mem_addr;
    logic [7:0]  ccr, mem_wdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit chk_on   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ctlx_seq #(.PC_RST(PC_RST), .SP_RST(SP_RST), .CCR_RST(CCR_RST)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_vec(op_vec), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .pc(pc), .sp(sp), .ccr(ccr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    function automatic logic [7:0] init_byte(int a);
        case (a)
            'h000: return 8'hAB;  'h001: return 8'hCD;
            'h010: return 8'h12;  'h011: return 8'h34;
            'h0FF: return 8'h03;  'h100: return 8'h45;
            'h380: return 8'h2B;  'h381: return 8'hEE;
            'h382: return 8'h05;  'h383: return 8'h67;
            default: return 8'h00;
        endcase
    endfunction

    // Memory seen by the design: registered read, write at the edge.
    logic [7:0] dm [1024];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) dm[i] <= init_byte(i);
            mem_rdata <= 8'h00;
        end else begin
            if (mem_wr) dm[mem_addr[9:0]] <= mem_wdata;
            if (mem_rd) mem_rdata <= dm[mem_addr[9:0]];
        end
    end

    // Reference model.
    logic [7:0]  mm [1024];
    int          m_left;
    logic [1:0]  m_kind;
    logic [7:0]  m_vec;
    logic [15:0] m_pc, m_sp;
    logic [7:0]  m_ccr;

    task automatic model_commit();
        logic [15:0] r;
        logic [15:0] v;
        case (m_kind)
            2'b01: begin
                r = m_pc + 16'd2;
                m_sp = m_sp - 16'd2;
                mm[m_sp[9:0]] = r[15:8];
                mm[10'(m_sp + 16'd1)] = r[7:0];
                v = {8'h00, m_vec};
                m_pc = {mm[v[9:0]], mm[10'(v + 16'd1)]};
            end
            2'b10: begin
                m_pc = {mm[m_sp[9:0]], mm[10'(m_sp + 16'd1)]};
                m_sp = m_sp + 16'd2;
            end
            2'b11: begin
                m_ccr = mm[m_sp[9:0]];
                m_pc = {mm[10'(m_sp + 16'd2)], mm[10'(m_sp + 16'd3)]};
                m_sp = m_sp + 16'd4;
            end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mm[i] = init_byte(i);
            m_left = 0; m_kind = 2'b00; m_vec = 8'h00;
            m_pc = PC_RST; m_sp = SP_RST; m_ccr = CCR_RST;
        end else if (m_left > 0) begin
            if (m_left == 1) model_commit();
            m_left = m_left - 1;
        end else if (op_valid && op_kind != 2'b00) begin
            m_kind = op_kind;
            m_vec  = op_vec;
            m_left = (op_kind == 2'b11) ? 10 : 8;
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (chk_on) begin
            chk("R7 busy", 16'(busy), 16'(m_left > 0));
            chk("R7 done", 16'(done), 16'(m_left == 1));
            chk("R3 R4 R5 pc", pc, m_pc);
            chk("R3 R4 R5 sp", sp, m_sp);
            chk("R5 R6 ccr", 16'(ccr), 16'(m_ccr));
            chk("R9 one strobe", 16'(mem_rd && mem_wr), 16'd0);
            if (m_left == 0) chk("R9 idle strobes", 16'(mem_rd || mem_wr), 16'd0);
        end
    end

    // Issue one op, count busy and done cycles, optionally poke during busy.
    task automatic run_op(logic [1:0] k, logic [7:0] v, int n, bit poke);
        int nb = 0;
        int nd = 0;
        op_valid = 1'b1; op_kind = k; op_vec = v;
        @(negedge clk);
        op_valid = 1'b0; op_kind = 2'b00;
        while (busy) begin
            nb++;
            if (done) nd++;
            if (poke && nb == 2) begin
                op_valid = 1'b1; op_kind = 2'b10; op_vec = 8'h55;  // R8
            end else begin
                op_valid = 1'b0; op_kind = 2'b00;
            end
            @(negedge clk);
            if (nb > 20) break;
        end
        op_valid = 1'b0;
        chk("R7 busy length", 16'(nb), 16'(n));
        chk("R7 single done", 16'(nd), 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while held in reset.
        chk("R1 busy", 16'(busy), 16'd0);
        chk("R1 done", 16'(done), 16'd0);
        chk("R1 pc", pc, PC_RST);
        chk("R1 sp", sp, SP_RST);
        chk("R1 ccr", 16'(ccr), 16'(CCR_RST));
        chk("R1 strobes", 16'(mem_rd || mem_wr), 16'd0);
        rst_n = 1'b1;
        chk_on = 1'b1;
        @(negedge clk);

        // R3: call through vector 0x10, with a RET strobe injected mid-way (R8).
        run_op(2'b01, 8'h10, 8, 1'b1);
        chk("R3 pc from table", pc, 16'h1234);
        chk("R3 sp", sp, 16'h037E);
        chk("R3 pushed hi", 16'(dm[10'h37E]), 16'h0002);
        chk("R3 pushed lo", 16'(dm[10'h37F]), 16'h0002);
        chk("R8 no extra op", 16'(busy), 16'd0);

        // R3: vector 0xFF crosses into 0x0100 for the low byte.
        run_op(2'b01, 8'hFF, 8, 1'b0);
        chk("R3 vec FF pc", pc, 16'h0345);
        chk("R3 nested hi", 16'(dm[10'h37C]), 16'h0012);
        chk("R3 nested lo", 16'(dm[10'h37D]), 16'h0036);

        // R2: kind 00 with strobe is ignored.
        op_valid = 1'b1; op_kind = 2'b00;
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        chk("R2 none ignored busy", 16'(busy), 16'd0);
        chk("R2 none ignored pc", pc, 16'h0345);

        // R4, R6: two returns.
        run_op(2'b10, 8'h00, 8, 1'b0);
        chk("R4 pc", pc, 16'h1236);
        chk("R4 sp", sp, 16'h037E);
        run_op(2'b10, 8'h00, 8, 1'b0);
        chk("R4 pc outer", pc, 16'h0202);
        chk("R6 ccr kept", 16'(ccr), 16'h0080);

        // R5: exception return, byte at sp+1 unused.
        run_op(2'b11, 8'h00, 10, 1'b0);
        chk("R5 ccr", 16'(ccr), 16'h002B);
        chk("R5 pc", pc, 16'h0567);
        chk("R5 sp", sp, 16'h0384);

        // R3/R4 back to back after the exception return; call via vector 0.
        run_op(2'b01, 8'h00, 8, 1'b0);
        chk("R3 vec 0 pc", pc, 16'hABCD);
        chk("R6 ccr after call", 16'(ccr), 16'h002B);
        run_op(2'b10, 8'h00, 8, 1'b0);
        chk("R4 return after rte", pc, 16'h0569);
        chk("R4 sp restored", sp, 16'h0384);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule